// File: doc/BRIEF.md
# Single-Buffer Register-Mapped UART

A serial port peripheral that sits on a simple synchronous register bus and moves 8-bit characters over a transmit and receive pin pair. Each frame has one start bit, eight data bits sent least significant bit first, and one stop bit. There is no parity. Software sets the bit period directly in clock cycles. Each direction buffers exactly one character. When a character is lost because a buffer was still occupied, the port records the loss instead of stalling.

Software enables each direction separately and picks which events raise an interrupt. It clears event flags by writing ones to them. There are three interrupt pins. One says the transmit buffer has been handed to the shifter. One says a received character is waiting. The third is shared by both kinds of lost-character event.

The bus uses word addresses. The offset picks the register (0x00 data, 0x04 status, 0x08 control, 0x0C interrupt flags, 0x10 bit period), and address bits [1:0] are ignored. A read returns its data on `bus_rdata` in the clock cycle after the select. Reads of unmapped offsets return zero.

Top module: `sbuf_uart`

## Requirements
- R1: After reset, status, control and interrupt flags read 0, the bit period reads 16, `ser_tx` is high and all three interrupt pins are low. Read data appears on `bus_rdata` one cycle after a read select.
- R2: Control (0x08) keeps write-data bits [5:0]: bit0 transmit enable, bit1 receive enable, bit2 transmit interrupt enable, bit3 receive interrupt enable, bit4 transmit-overrun interrupt enable, bit5 receive-overrun interrupt enable. All higher bits read 0.
- R3: The bit period register (0x10) holds 21 bits (write-data bits [20:0]). A written value below 16 is stored as 16.
- R4: While transmit is enabled, each character goes out as a low start bit, eight data bits least significant first, and a high stop bit. Each bit lasts one bit period. While transmit is disabled, `ser_tx` stays high and the held character waits.
- R5: Writing 0x00 while status bit0 (transmit buffer full) is clear stores write-data bits [7:0] and sets bit0. When the character moves into the shifter, bit0 clears and interrupt flag bit0 sets.
- R6: Writing 0x00 while status bit0 is set discards the new character. It also sets status bit2 and interrupt flag bit2 (transmit overrun).
- R7: While receive is enabled, a valid frame sets status bit1 and interrupt flag bit1. Reading 0x00 returns the character in bits [7:0] and clears status bit1. Frames that arrive while receive is disabled are ignored.
- R8: A frame that completes while status bit1 is set is dropped, and status bit3 and interrupt flag bit3 (receive overrun) set. The character already held is kept.
- R9: A falling edge starts reception only if the line is still low half a bit period later. A frame whose stop bit samples low is discarded without setting any flag.
- R10: Writing the interrupt flag register (0x0C) clears each flag written as 1 and leaves each flag written as 0 unchanged. Status bits 2 and 3 mirror flag bits 2 and 3.
- R11: `irq_tx` is flag bit0 AND control bit2. `irq_rx` is flag bit1 AND control bit3. `irq_ovr` is (flag bit2 AND control bit4) OR (flag bit3 AND control bit5).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read |
| ser_rx | input | 1 | Serial receive line (idle high) |
| ser_tx | output | 1 | Serial transmit line (idle high) |
| irq_tx | output | 1 | Transmit buffer freed interrupt |
| irq_rx | output | 1 | Character received interrupt |
| irq_ovr | output | 1 | Combined overrun interrupt |

## Verification
The embedded assertions check the following on every cycle:
- the stored bit period never drops below 16;
- a start bit is low and a stop bit is high on the transmit line;
- a hand-off to the shifter frees the buffer and raises the transmit flag;
- a write into a full transmit buffer, or a completed frame into a full receive buffer, sets the matching overrun flag;
- a delivered character always had a high stop sample;
- the receive-full bit only rises after a delivered frame.

Only the bench scenarios can show the end-to-end behaviour:
- the bit ordering and bit timing on the pins;
- the rejection of a short start glitch;
- which of two racing characters survives an overrun;
- the selective clearing of flags by write-one-to-clear;
- the gating of each interrupt pin by its enable.

// File: rtl/sbuf_uart_pkg.sv
package sbuf_uart_pkg;

  // Word index of each register (byte address bits [4:2])
  typedef enum logic [2:0] {
    REG_DATA = 3'd0,
    REG_STAT = 3'd1,
    REG_CTRL = 3'd2,
    REG_FLAG = 3'd3,
    REG_DIV  = 3'd4
  } reg_sel_e;

  // Control register, bit5 down to bit0
  typedef struct packed {
    logic ovr_rx_ie;
    logic ovr_tx_ie;
    logic rx_ie;
    logic tx_ie;
    logic rx_en;
    logic tx_en;
  } ctrl_t;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/sbuf_uart_tx.sv
module sbuf_uart_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_byte,
  output logic              load,
  output logic              txd,
  output logic              busy
);
  localparam int FRAME = DATA_W + 2;
  localparam int IDX_W = $clog2(FRAME);

  logic [FRAME-1:0] sh_q;
  logic [DIV_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;

  assign load = !busy_q && en && hold_valid;
  assign busy = busy_q;
  assign txd  = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (load) begin
        sh_q   <= {1'b1, hold_byte, 1'b0};
        cnt_q  <= div - DIV_W'(1);
        idx_q  <= '0;
        busy_q <= 1'b1;
      end
    end else if (cnt_q == '0) begin
      cnt_q <= div - DIV_W'(1);
      if (idx_q == IDX_W'(FRAME - 1)) begin
        busy_q <= 1'b0;
      end else begin
        sh_q  <= {1'b1, sh_q[FRAME-1:1]};
        idx_q <= idx_q + IDX_W'(1);
      end
    end else begin
      cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  // R4
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy_q && !txd));
  // R4
  tx_stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(txd));

endmodule

// File: rtl/sbuf_uart_rx.sv
module sbuf_uart_rx
  import sbuf_uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int BIT_W = $clog2(DATA_W);

  logic [2:0]        sync_q;
  logic              line, fall;
  rx_state_e         st_q;
  logic [DIV_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  nbit_q;
  logic [DATA_W-1:0] sh_q;
  logic              done_q;

  assign line    = sync_q[1];
  assign fall    = sync_q[2] && !sync_q[1];
  assign done    = done_q;
  assign rx_byte = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      nbit_q <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[1:0], rxd};
      done_q <= 1'b0;
      case (st_q)
        RX_IDLE: if (en && fall) begin
          st_q  <= RX_START;
          cnt_q <= (div >> 1) - DIV_W'(1);
        end
        RX_START: if (cnt_q == '0) begin
          if (!line) begin
            st_q   <= RX_DATA;
            cnt_q  <= div - DIV_W'(1);
            nbit_q <= '0;
          end else begin
            st_q <= RX_IDLE;
          end
        end else cnt_q <= cnt_q - DIV_W'(1);
        RX_DATA: if (cnt_q == '0) begin
          sh_q   <= {line, sh_q[DATA_W-1:1]};
          cnt_q  <= div - DIV_W'(1);
          nbit_q <= nbit_q + BIT_W'(1);
          if (nbit_q == BIT_W'(DATA_W - 1)) st_q <= RX_STOP;
        end else cnt_q <= cnt_q - DIV_W'(1);
        default: if (cnt_q == '0) begin
          done_q <= line;
          st_q   <= RX_IDLE;
        end else cnt_q <= cnt_q - DIV_W'(1);
      endcase
    end
  end

  // R9
  rx_stop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(line));

endmodule

// File: rtl/sbuf_uart.sv
module sbuf_uart
  import sbuf_uart_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int BUS_W   = 32,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 21,
  parameter int MIN_DIV = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ser_rx,
  output logic              ser_tx,
  output logic              irq_tx,
  output logic              irq_rx,
  output logic              irq_ovr
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int CTRL_W = $bits(ctrl_t);

  function automatic logic [DIV_W-1:0] clamp_div(input logic [BUS_W-1:0] w);
    logic [DIV_W-1:0] v;
    v = w[DIV_W-1:0];
    return (v < DIV_W'(MIN_DIV)) ? DIV_W'(MIN_DIV) : v;
  endfunction

  function automatic logic hit(input logic [IDX_W-1:0] idx, input reg_sel_e r);
    return idx == IDX_W'(r);
  endfunction

  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [3:0]        flags_q;   // {rx_ovr, tx_ovr, rx, tx}
  logic              tx_full, rx_full;
  logic [DATA_W-1:0] tx_hold, rx_hold;
  logic [BUS_W-1:0]  rdata_q;

  // Named internal events
  logic [IDX_W-1:0]  idx;
  logic              wr_data, wr_ctrl, wr_flag, wr_div, rd_any, rd_data;
  logic              tx_load, tx_busy, rx_done;
  logic [DATA_W-1:0] rx_byte;
  logic [3:0]        flag_set, flag_clr;
  logic              unused_ok;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign wr_data = bus_sel && bus_wr && hit(idx, REG_DATA);
  assign wr_ctrl = bus_sel && bus_wr && hit(idx, REG_CTRL);
  assign wr_flag = bus_sel && bus_wr && hit(idx, REG_FLAG);
  assign wr_div  = bus_sel && bus_wr && hit(idx, REG_DIV);
  assign rd_any  = bus_sel && !bus_wr;
  assign rd_data = rd_any && hit(idx, REG_DATA);
  assign unused_ok = ^{bus_addr[1:0], bus_wdata};

  sbuf_uart_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.tx_en), .div(div_q),
    .hold_valid(tx_full), .hold_byte(tx_hold),
    .load(tx_load), .txd(ser_tx), .busy(tx_busy));

  sbuf_uart_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(ctrl_q.rx_en), .div(div_q),
    .rxd(ser_rx), .done(rx_done), .rx_byte(rx_byte));

  assign flag_set = {rx_done && rx_full, wr_data && tx_full,
                     rx_done && !rx_full, tx_load};
  assign flag_clr = wr_flag ? bus_wdata[3:0] : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      div_q   <= DIV_W'(MIN_DIV);
      flags_q <= '0;
      tx_full <= 1'b0;
      rx_full <= 1'b0;
      tx_hold <= '0;
      rx_hold <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (wr_div)  div_q  <= clamp_div(bus_wdata);
      flags_q <= (flags_q & ~flag_clr) | flag_set;

      if (wr_data && !tx_full) begin
        tx_hold <= bus_wdata[DATA_W-1:0];
        tx_full <= 1'b1;
      end else if (tx_load) begin
        tx_full <= 1'b0;
      end

      if (rx_done && !rx_full) begin
        rx_hold <= rx_byte;
        rx_full <= 1'b1;
      end else if (rd_data) begin
        rx_full <= 1'b0;
      end

      if (rd_any) begin
        case (idx)
          IDX_W'(REG_DATA): rdata_q <= BUS_W'(rx_hold);
          IDX_W'(REG_STAT): rdata_q <= BUS_W'({flags_q[3:2], rx_full, tx_full});
          IDX_W'(REG_CTRL): rdata_q <= BUS_W'(ctrl_q);
          IDX_W'(REG_FLAG): rdata_q <= BUS_W'(flags_q);
          IDX_W'(REG_DIV):  rdata_q <= BUS_W'(div_q);
          default:          rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_tx    = flags_q[0] && ctrl_q.tx_ie;
  assign irq_rx    = flags_q[1] && ctrl_q.rx_ie;
  assign irq_ovr   = (flags_q[2] && ctrl_q.ovr_tx_ie) || (flags_q[3] && ctrl_q.ovr_rx_ie);

  // R3
  div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_q >= DIV_W'(MIN_DIV));
  // R5
  tx_load_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> (!tx_full && flags_q[0]));
  // R6
  tx_ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && tx_full) |=> flags_q[2]);
  // R7
  rx_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_done));
  // R8
  rx_ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full) |=> (flags_q[3] && rx_full));
  // R10
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && !bus_wdata[1] && flags_q[1]) |=> flags_q[1]);

endmodule

// File: tb/sbuf_uart_tb.sv
`timescale 1ns/1ps
module sbuf_uart_tb;
  localparam int BIT = 16;
  localparam logic [4:0] A_DATA = 5'h00, A_STAT = 5'h04, A_CTRL = 5'h08,
                         A_FLAG = 5'h0C, A_DIV = 5'h10;
  // {stimulus byte, expected byte at the far side}
  localparam logic [15:0] VEC [6] = '{16'h5555, 16'hA3A3, 16'h0000,
                                      16'hFFFF, 16'h8181, 16'h3C3C};

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ser_rx = 1'b1;
  logic ser_tx, irq_tx, irq_rx, irq_ovr;
  int n_chk = 0, n_err = 0;
  logic finished = 1'b0;

  always #2.5 clk = ~clk;

  sbuf_uart u_dut (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_ovr(irq_ovr));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  // Capture one frame from ser_tx: returns {stop, data, start}
  task automatic tx_capture(output logic [9:0] f);
    int w = 0;
    f = '0;
    while (ser_tx !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    repeat (BIT/2) @(negedge clk);
    f[0] = ser_tx;
    for (int i = 1; i < 10; i++) begin
      repeat (BIT) @(negedge clk);
      f[i] = ser_tx;
    end
  endtask

  task automatic rx_drive(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); ser_rx = f[i];
      repeat (BIT - 1) @(negedge clk);
    end
    @(negedge clk); ser_rx = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [9:0]  f;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 ser_tx idle", 32'(ser_tx), 32'd1);
    check("R1 irqs", 32'({irq_tx, irq_rx, irq_ovr}), 32'd0);
    rd_chk("R1 status", A_STAT, 32'h0);
    rd_chk("R1 control", A_CTRL, 32'h0);
    rd_chk("R1 flags", A_FLAG, 32'h0);
    rd_chk("R1 divisor", A_DIV, 32'd16);

    // R2 control width
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd_chk("R2 control readback", A_CTRL, 32'h3F);
    wr(A_CTRL, 32'h0);
    // R3 divisor clamp and width
    wr(A_DIV, 32'd5);
    rd_chk("R3 divisor floor", A_DIV, 32'd16);
    wr(A_DIV, 32'hFFFF_FFFF);
    rd_chk("R3 divisor width", A_DIV, 32'h1F_FFFF);
    wr(A_DIV, 32'd16);
    wr(A_CTRL, 32'h03);

    // Table walk: transmit and receive each vector
    for (int v = 0; v < 6; v++) begin
      wr(A_DATA, {24'h0, VEC[v][15:8]});
      tx_capture(f);
      check("R4 start bit", 32'(f[0]), 32'd0);
      check("R4 tx data", 32'(f[8:1]), 32'(VEC[v][7:0]));
      check("R4 stop bit", 32'(f[9]), 32'd1);
      rd_chk("R5 tx flag", A_FLAG, 32'h1);
      wr(A_FLAG, 32'hF);
      rx_drive(VEC[v][15:8], 1'b1);
      rd_chk("R7 rx full", A_STAT, 32'h2);
      rd_chk("R7 rx data", A_DATA, 32'(VEC[v][7:0]));
      rd_chk("R7 rx full cleared", A_STAT, 32'h0);
      rd_chk("R7 rx flag", A_FLAG, 32'h2);
      wr(A_FLAG, 32'hF);
    end

    // R4/R5/R6 transmit held while disabled, overrun discards second byte
    wr(A_CTRL, 32'h02);
    wr(A_DATA, 32'h5A);
    rd_chk("R5 tx full", A_STAT, 32'h1);
    repeat (40) @(negedge clk);
    check("R4 idle while disabled", 32'(ser_tx), 32'd1);
    wr(A_DATA, 32'h77);
    rd_chk("R6 tx overrun status", A_STAT, 32'h5);
    rd_chk("R6 tx overrun flag", A_FLAG, 32'h4);
    wr(A_CTRL, 32'h13);
    tx_capture(f);
    check("R6 first byte kept", 32'(f[8:1]), 32'h5A);
    check("R11 irq_ovr on tx overrun", 32'(irq_ovr), 32'd1);
    check("R11 irq_tx gated", 32'(irq_tx), 32'd0);
    wr(A_FLAG, 32'h4);
    rd_chk("R10 clear only written bit", A_FLAG, 32'h1);
    check("R11 irq_ovr drops", 32'(irq_ovr), 32'd0);
    wr(A_FLAG, 32'h0);
    rd_chk("R10 zero write keeps", A_FLAG, 32'h1);
    wr(A_CTRL, 32'h07);
    check("R11 irq_tx enabled", 32'(irq_tx), 32'd1);
    wr(A_FLAG, 32'h1);
    check("R11 irq_tx cleared", 32'(irq_tx), 32'd0);

    // R8 receive overrun keeps first byte
    wr(A_CTRL, 32'h23);
    rx_drive(8'h11, 1'b1);
    rx_drive(8'h22, 1'b1);
    rd_chk("R8 rx overrun status", A_STAT, 32'hA);
    check("R11 irq_ovr on rx overrun", 32'(irq_ovr), 32'd1);
    rd_chk("R8 first byte kept", A_DATA, 32'h11);
    rd_chk("R8 rx overrun flag", A_FLAG, 32'hA);
    wr(A_FLAG, 32'hF);

    // R7 receive disabled ignores frames
    wr(A_CTRL, 32'h01);
    rx_drive(8'h33, 1'b1);
    rd_chk("R7 rx disabled", A_STAT, 32'h0);

    // R9 short start glitch rejected
    wr(A_CTRL, 32'h0B);
    @(negedge clk); ser_rx = 1'b0;
    repeat (4) @(negedge clk);
    ser_rx = 1'b1;
    repeat (200) @(negedge clk);
    rd_chk("R9 glitch rejected", A_STAT, 32'h0);
    // R9 bad stop bit discarded
    rx_drive(8'h44, 1'b0);
    repeat (40) @(negedge clk);
    rd_chk("R9 bad stop status", A_STAT, 32'h0);
    rd_chk("R9 bad stop flags", A_FLAG, 32'h0);
    rx_drive(8'h66, 1'b1);
    check("R11 irq_rx enabled", 32'(irq_rx), 32'd1);
    rd(A_DATA, d);
    check("R9 recovery byte", d, 32'h66);
    wr(A_FLAG, 32'h2);
    check("R11 irq_rx cleared", 32'(irq_rx), 32'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule